// File: doc/BRIEF.md
# Depth Plane Capture Packer

This block sits behind a video receiver whose 24-bit pixel transfers carry depth rather than colour. Only the low byte of each transfer holds depth; the other sixteen bits are thrown away. The kept bytes are gathered into 256-bit words, 32 bytes per word, and written as one contiguous depth plane per frame. Compared with storing whole transfers, this needs a third of the bus writes.

Frames go into a ring of equally sized buffers. The consumer hands out credits, one token per free buffer. A frame is captured only if a credit is held when its first pixel arrives, so the writer never overwrites a buffer the consumer is still reading. When the last word of a frame has been issued, the block pulses a completion token. A frame that begins with no credit held is skipped in full, and a saturating drop counter records it.

Top module: `depth_packer`

## Requirements
- R1: After reset there are no writes, no completion token, a drop count of zero and no credits held.
- R2: Only bits [7:0] of each stored pixel transfer reach memory. Bits [23:8] have no effect on any output.
- R3: The k-th stored byte of a word (k = 0..31) sits at wr_data bits [8k+7:8k]. wr_req is high for the one cycle after the clock edge that took the 32nd byte.
- R4: Within a frame, successive words go to addresses that rise by 32, starting at the base of the frame's buffer.
- R5: The base of buffer i is BASE_ADDR + i*FRAME_BYTES. Buffers are used in the order 0, 1, ..., NUM_BUF-1 and then again from 0, one buffer per captured frame.
- R6: tok_done pulses for exactly one cycle, in the same cycle as the write of a frame's last word. A frame is FRAME_BYTES stored pixels.
- R7: A frame start (pix_sof with pix_valid) that arrives while no credit is held causes the whole frame to be skipped, with no writes and no token. drop_count rises by one and saturates at its maximum.
- R8: Capture begins only on a frame-start pixel while a credit is held, and that start consumes one credit. Valid pixels without pix_sof are ignored while no frame is being captured. A token arriving in the same cycle as a frame start counts only from the next cycle.
- R9: Each tok_free pulse adds one credit. The credit count saturates at NUM_BUF, and any further tokens are ignored.
- R10: Cycles with pix_valid low add no byte and do not advance the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Pixel transfer valid (line active) |
| pix_sof | input | 1 | Marks the first pixel of a frame |
| pix_data | input | PIX_W | Pixel transfer; depth in the low byte |
| tok_free | input | 1 | One-cycle pulse: one buffer is free |
| tok_done | output | 1 | One-cycle pulse: a frame is fully written |
| wr_req | output | 1 | Write request strobe |
| wr_addr | output | ADDR_W | Byte address of the written word |
| wr_data | output | BUS_W | Packed depth word |
| drop_count | output | DROP_W | Saturating count of skipped frames |

## Verification
The bench builds the block with NUM_BUF = 3, FRAME_BYTES = 64 and BASE_ADDR = 0x1000. With three buffers the index wraps at a value that is not a power of two, and with two words per frame the 32-byte address step and the completion token on the second word both occur in every frame. With this small ring, a burst of five tokens saturates the credit count, and the fourth of four frames is then dropped. A token given in the same cycle as a frame start shows that the start is decided from the credit already held.

// File: rtl/dp_pkg.sv
// Shared types for the depth plane capture packer.
// Assumes nothing beyond the parameters of its users.
package dp_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CAP  = 1'b1
    } cap_state_e;
endpackage

// File: rtl/dp_credit.sv
// Buffer credit counter and ring index.
// Holds up to NUM_BUF free-buffer credits and hands one out per accepted
// frame. The ring index advances when a captured frame ends.
// Assumes take is raised only while avail is high.
module dp_credit #(
    parameter int NUM_BUF = 3,
    localparam int CRD_W = $clog2(NUM_BUF + 1),
    localparam int IDX_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_in,
    input  logic             take,
    input  logic             frame_end,
    output logic             avail,
    output logic [IDX_W-1:0] buf_idx
);
    logic [CRD_W-1:0] cnt_q;
    logic [CRD_W:0]   cnt_sum;

    // Next credit level, clamped to the ring size.
    always_comb begin
        cnt_sum = {1'b0, cnt_q} + {{CRD_W{1'b0}}, tok_in} - {{CRD_W{1'b0}}, take};
        if (cnt_sum > (CRD_W+1)'(NUM_BUF)) cnt_sum = (CRD_W+1)'(NUM_BUF);
    end

    // Credit register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_sum[CRD_W-1:0];
    end

    // Ring index, wrapping after the last buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            buf_idx <= '0;
        else if (frame_end)
            buf_idx <= (buf_idx == IDX_W'(NUM_BUF - 1)) ? '0 : buf_idx + 1'b1;
    end

    assign avail = (cnt_q != '0);

    // R8: a frame is never started without a held credit.
    a_r8_take_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> cnt_q != '0);
    // R9: the credit level never exceeds the ring size.
    a_r9_credit_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CRD_W'(NUM_BUF));
    // R5: the ring index stays inside the ring.
    a_r5_idx_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        buf_idx < IDX_W'(NUM_BUF));
endmodule

// File: rtl/dp_frame_ctl.sv
// Frame admission and pixel counting.
// Starts a capture on a frame-start pixel if a credit is held. Otherwise
// it flags a drop and ignores pixels until the next frame start. It marks
// the last of FRAME_BYTES stored pixels.
// Assumes FRAME_BYTES >= 1 and that pix_sof does not recur mid-capture.
module dp_frame_ctl
    import dp_pkg::*;
#(
    parameter int FRAME_BYTES = 64,
    localparam int PCNT_W = $clog2(FRAME_BYTES) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_valid,
    input  logic pix_sof,
    input  logic credit_avail,
    output logic start,
    output logic drop,
    output logic store,
    output logic last
);
    cap_state_e        state_q;
    logic [PCNT_W-1:0] pcnt_q;

    // Admission decisions for the current transfer.
    always_comb begin
        start = pix_valid && pix_sof && (state_q == ST_IDLE) && credit_avail;
        drop  = pix_valid && pix_sof && (state_q == ST_IDLE) && !credit_avail;
        store = start || (pix_valid && (state_q == ST_CAP));
        last  = store && (pcnt_q == PCNT_W'(FRAME_BYTES - 1));
    end

    // Capture state: enter on start, leave after the last stored pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)     state_q <= ST_IDLE;
        else if (last)  state_q <= ST_IDLE;
        else if (start) state_q <= ST_CAP;
    end

    // Stored-pixel counter within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)     pcnt_q <= '0;
        else if (last)  pcnt_q <= '0;
        else if (store) pcnt_q <= pcnt_q + 1'b1;
    end

    // R8: capture is entered only from a frame-start pixel.
    a_r8_cap_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAP && $past(state_q) == ST_IDLE) |-> $past(pix_sof && pix_valid));
    // R7: a dropped frame leaves the block idle.
    a_r7_drop_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> state_q == ST_IDLE);
endmodule

// File: rtl/dp_lane_pack.sv
// Byte-to-word packer and write address generator.
// Places each stored byte in the next lane of a BUS_W word. It issues a
// write once all lanes are filled, at the next contiguous address of the
// current buffer, and raises the completion token with the frame's last word.
// Assumes FRAME_BYTES is a multiple of BUS_W/DEPTH_W.
module dp_lane_pack #(
    parameter int DEPTH_W     = 8,
    parameter int BUS_W       = 256,
    parameter int ADDR_W      = 32,
    parameter int FRAME_BYTES = 64,
    parameter int NUM_BUF     = 3,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    localparam int LANES  = BUS_W / DEPTH_W,
    localparam int LANE_W = $clog2(LANES),
    localparam int WORD_BYTES = BUS_W / 8,
    localparam int WORDS  = FRAME_BYTES / LANES,
    localparam int WCNT_W = $clog2(WORDS) + 1,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               store,
    input  logic               last,
    input  logic [DEPTH_W-1:0] depth,
    input  logic [IDX_W-1:0]   buf_idx,
    output logic               wr_req,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [BUS_W-1:0]   wr_data,
    output logic               tok_done
);
    logic [LANE_W-1:0] lane_q;
    logic [WCNT_W-1:0] word_q;
    logic [BUS_W-1:0]  acc_q;
    logic [BUS_W-1:0]  acc_next;
    logic              word_full;
    logic [ADDR_W-1:0] word_addr;

    // Merge the incoming byte into its lane.
    always_comb begin
        acc_next = acc_q;
        acc_next[lane_q*DEPTH_W +: DEPTH_W] = depth;
        word_full = store && (lane_q == LANE_W'(LANES - 1));
        word_addr = BASE_ADDR
                  + ADDR_W'(buf_idx) * ADDR_W'(FRAME_BYTES)
                  + ADDR_W'(word_q) * ADDR_W'(WORD_BYTES);
    end

    // Lane accumulator and lane pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            lane_q <= '0;
        end else if (store) begin
            acc_q  <= acc_next;
            lane_q <= word_full ? '0 : lane_q + 1'b1;
        end
    end

    // Word counter within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)         word_q <= '0;
        else if (last)      word_q <= '0;
        else if (word_full) word_q <= word_q + 1'b1;
    end

    // Registered write port and completion token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_req   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            tok_done <= 1'b0;
        end else begin
            wr_req   <= word_full;
            tok_done <= last;
            if (word_full) begin
                wr_addr <= word_addr;
                wr_data <= acc_next;
            end
        end
    end

    // R6: a completion token always travels with a write.
    a_r6_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        tok_done |-> wr_req);
    // R3: a write follows a stored byte in the previous cycle.
    a_r3_write_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> $past(store));
    // R4: addresses are word aligned.
    a_r4_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_addr % ADDR_W'(WORD_BYTES)) == (BASE_ADDR % ADDR_W'(WORD_BYTES)));
endmodule

// File: rtl/depth_packer.sv
// Depth plane capture packer, top level.
// Keeps the low DEPTH_W bits of each pixel transfer and packs them into
// BUS_W words written to a ring of NUM_BUF frame buffers, gated by
// free-buffer credits. It counts frames skipped for lack of credit.
// Assumes writes are always accepted and FRAME_BYTES is a multiple of 32.
module depth_packer #(
    parameter int PIX_W       = 24,
    parameter int DEPTH_W     = 8,
    parameter int BUS_W       = 256,
    parameter int ADDR_W      = 32,
    parameter int NUM_BUF     = 3,
    parameter int FRAME_BYTES = 64,
    parameter int DROP_W      = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              pix_sof,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              tok_free,
    output logic              tok_done,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BUS_W-1:0]  wr_data,
    output logic [DROP_W-1:0] drop_count
);
    localparam int IDX_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;

    logic             credit_avail;
    logic [IDX_W-1:0] buf_idx;
    logic             start, drop, store, last;
    logic             unused_hi;

    assign unused_hi = ^pix_data[PIX_W-1:DEPTH_W];

    dp_credit #(.NUM_BUF(NUM_BUF)) u_credit (
        .clk(clk), .rst_n(rst_n), .tok_in(tok_free), .take(start),
        .frame_end(last), .avail(credit_avail), .buf_idx(buf_idx)
    );

    dp_frame_ctl #(.FRAME_BYTES(FRAME_BYTES)) u_frame (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
        .credit_avail(credit_avail), .start(start), .drop(drop),
        .store(store), .last(last)
    );

    dp_lane_pack #(
        .DEPTH_W(DEPTH_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
        .FRAME_BYTES(FRAME_BYTES), .NUM_BUF(NUM_BUF), .BASE_ADDR(BASE_ADDR)
    ) u_pack (
        .clk(clk), .rst_n(rst_n), .store(store), .last(last),
        .depth(pix_data[DEPTH_W-1:0]), .buf_idx(buf_idx),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .tok_done(tok_done)
    );

    // Saturating count of frames skipped for lack of credit.
    always_ff @(posedge clk) begin
        if (!rst_n)                     drop_count <= '0;
        else if (drop && drop_count != '1) drop_count <= drop_count + 1'b1;
    end

    // R7: the drop count moves only by single steps.
    a_r7_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        drop_count != $past(drop_count) |-> drop_count == $past(drop_count) + 1'b1);
endmodule

// File: tb/depth_packer_tb.sv
// Bench for depth_packer: a behavioural reference model is stepped on every
// rising edge and compared with the outputs on every falling edge.
module depth_packer_tb;
    localparam int NB = 3;
    localparam int FB = 64;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pix_valid = 1'b0;
    logic         pix_sof = 1'b0;
    logic [23:0]  pix_data = '0;
    logic         tok_free = 1'b0;
    logic         tok_done;
    logic         wr_req;
    logic [31:0]  wr_addr;
    logic [255:0] wr_data;
    logic [7:0]   drop_count;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string phase = "R1";

    depth_packer #(.NUM_BUF(NB), .FRAME_BYTES(FB), .BASE_ADDR(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
        .pix_data(pix_data), .tok_free(tok_free), .tok_done(tok_done),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .drop_count(drop_count)
    );

    always #5 clk = ~clk;

    // Reference model state.
    int           m_cred, m_idx, m_pcnt, m_word, m_drop;
    bit           m_cap;
    byte unsigned m_q[$];
    bit           e_req, e_done;
    logic [31:0]  e_addr;
    logic [255:0] e_data;

    task automatic check(input bit ok, input string what, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s [%s] act=%0h exp=%0h", what, phase, act, exp);
        end
    endtask

    // Model step on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cred = 0; m_idx = 0; m_pcnt = 0; m_word = 0; m_drop = 0;
            m_cap = 0; m_q.delete(); e_req = 0; e_done = 0; e_addr = '0; e_data = '0;
        end else begin
            bit take;
            take = 0;
            e_req = 0;
            e_done = 0;
            if (pix_valid) begin
                if (!m_cap && pix_sof) begin
                    if (m_cred > 0) begin
                        m_cap = 1; take = 1; m_pcnt = 0; m_word = 0;
                    end else if (m_drop < 255) m_drop++;
                end
                if (m_cap) begin
                    m_q.push_back(pix_data[7:0]);
                    m_pcnt++;
                    if (m_q.size() == 32) begin
                        for (int k = 0; k < 32; k++) e_data[8*k +: 8] = m_q[k];
                        m_q.delete();
                        e_req = 1;
                        e_addr = BASE + 32'(m_idx * FB + m_word * 32);
                        m_word++;
                    end
                    if (m_pcnt == FB) begin
                        e_done = 1;
                        m_cap = 0;
                        m_idx = (m_idx + 1) % NB;
                    end
                end
            end
            m_cred = m_cred - int'(take) + int'(tok_free);
            if (m_cred > NB) m_cred = NB;
        end
    end

    // Compare on each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(wr_req == e_req, "R3 wr_req", 256'(wr_req), 256'(e_req));
            if (e_req && wr_req) begin
                check(wr_addr == e_addr, "R4 R5 wr_addr", 256'(wr_addr), 256'(e_addr));
                check(wr_data == e_data, "R2 R3 wr_data", wr_data, e_data);
            end
            check(tok_done == e_done, "R6 tok_done", 256'(tok_done), 256'(e_done));
            check(drop_count == 8'(m_drop), "R7 drop_count", 256'(drop_count), 256'(m_drop));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog [%s] act=%0d exp=<20000", phase, cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_valid = 0; pix_sof = 0; tok_free = 0;
        end
    endtask

    task automatic give_tokens(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_valid = 0; pix_sof = 0; tok_free = 1;
        end
        @(negedge clk);
        tok_free = 0;
    endtask

    task automatic send_frame(input bit gaps, input bit tok_at_sof);
        for (int i = 0; i < FB; i++) begin
            if (gaps && (i % 3 == 2)) begin
                @(negedge clk);
                pix_valid = 0; pix_sof = 0; tok_free = 0; pix_data = 24'($urandom);
            end
            @(negedge clk);
            pix_valid = 1;
            pix_sof = (i == 0);
            tok_free = tok_at_sof && (i == 0);
            pix_data = 24'($urandom);
        end
        idle(3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state at the ports.
        check(wr_req == 0, "R1 wr_req", 256'(wr_req), 0);
        check(tok_done == 0, "R1 tok_done", 256'(tok_done), 0);
        check(drop_count == 0, "R1 drop_count", 256'(drop_count), 0);
        // R1 R7: no credit after reset, so this frame is skipped.
        phase = "R1 R7";
        send_frame(0, 0);
        // R8: valid pixels without frame start are ignored, with and without credit.
        phase = "R8";
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); pix_valid = 1; pix_sof = 0; pix_data = 24'($urandom);
        end
        give_tokens(2);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); pix_valid = 1; pix_sof = 0; pix_data = 24'($urandom);
        end
        idle(2);
        // R2 R3 R4 R6: contiguous frame with random upper bits.
        phase = "R2 R3 R4 R6";
        send_frame(0, 0);
        // R10: frame with idle gaps inside the line.
        phase = "R10";
        send_frame(1, 0);
        // R8: token in the same cycle as a frame start with no credit -> dropped.
        phase = "R8 R7";
        send_frame(0, 1);
        // R5: the late token is then used; buffer index 2.
        phase = "R5";
        send_frame(0, 0);
        // R9: five tokens saturate at three; index wraps 0,1,2; fourth frame dropped.
        phase = "R9 R5";
        give_tokens(5);
        for (int f = 0; f < 4; f++) send_frame(f == 1, 0);
        idle(5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule